// File: doc/BRIEF.md
# I2C Bus Idle Watchdog and Stuck-Bus Recovery

This block watches the local SCL and SDA lines of an I2C bus and decides, from a period of silence, whether the bus is free or hung. Every transition on either line restarts an inactivity timer. The timer counts ticks of a fixed-frequency oscillator, and its length is derived at elaboration from the oscillator frequency parameter. A control input picks between a long window of about one second and a short window of about fifty microseconds.

When the window runs out, the level of SDA decides what happens next. If SDA is high, the bus is reported free. The free indication stays up until the next line edge. If SDA is low, some slave is assumed to be holding the data line. The block then pulls SCL low and releases it nine times so that the slave can finish its byte and let go. Each pulse's low and high times are programmable in 50 ns units. Recovery stops at once if SDA rises. After recovery, whether it finished or stopped early, the watchdog starts a fresh inactivity window. A disable input turns off detection and recovery entirely.

The inputs are already-filtered line samples. The SCL pull-low output is meant to drive an open-drain pad, which is outside this block.

Top module: `i2c_bus_sentinel`

## Requirements
- R1: After reset, `bus_free`, `scl_pull` and `recovering` are all 0.
- R2: Any change of `scl_in` or `sda_in` restarts the inactivity window, so that no timeout outcome appears until a full window has passed since the last edge.
- R3: With `wd_fast` = 0, the window is LONG_US microseconds of `osc_tick` (OSC_HZ/1e6 ticks per microsecond).
- R4: With `wd_fast` = 1, the window is SHORT_US microseconds of `osc_tick`.
- R5: When the window expires with `sda_in` = 1, `bus_free` goes to 1 and no recovery pulses are driven. `bus_free` and `recovering` are never 1 together.
- R6: When the window expires with `sda_in` = 0, `recovering` goes to 1 and `scl_pull` makes exactly 9 low pulses (rising edges of `scl_pull`), after which `recovering` returns to 0.
- R7: Each pulse holds `scl_pull` = 1 for `low_units` units and then 0 for `high_units` units. One unit is max(1, OSC_HZ/20e6) ticks, and a value of 0 counts as 1.
- R8: If `sda_in` is 1 while recovering, one clock later `scl_pull` and `recovering` are both 0.
- R9: After recovery ends, whether completed or aborted, a fresh full window passes before the next outcome.
- R10: While `bus_free` = 1, an edge on `scl_in` or `sda_in` clears it one clock later.
- R11: While `wd_disable` = 1, one clock later `bus_free`, `recovering` and `scl_pull` are 0 and stay 0, whatever the lines do.
- R12: `scl_pull` is 1 only while `recovering` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe at the oscillator rate |
| scl_in | input | 1 | Filtered SCL level |
| sda_in | input | 1 | Filtered SDA level |
| wd_disable | input | 1 | 1 turns off detection and recovery |
| wd_fast | input | 1 | 1 selects the short inactivity window |
| low_units | input | 8 | Recovery pulse low time, in 50 ns units |
| high_units | input | 8 | Recovery pulse high time, in 50 ns units |
| bus_free | output | 1 | Bus judged idle and free |
| scl_pull | output | 1 | Drive SCL low (recovery clock) |
| recovering | output | 1 | Recovery sequence in progress |

## Verification
The assertions check on every cycle the relations between outputs that must always hold. Pulls happen only during recovery, the free and recovering states exclude each other, and disable or a high SDA releases SCL on the next clock. A line edge drops the free flag, and a single recovery never exceeds nine pulses. Some properties need a stimulus history, and only the bench scenarios can show them. These are the exact window lengths for both speeds, the restart of the window after a late edge or after recovery, the exact count of nine pulses, the per-pulse low and high widths including the zero-unit case, and an abort partway through.

// File: rtl/i2c_sentinel_pkg.sv
package i2c_sentinel_pkg;

   typedef enum logic [1:0] {
      WD_WATCH   = 2'd0,
      WD_FREE    = 2'd1,
      WD_RECOVER = 2'd2
   } wd_state_e;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } pulse_phase_e;

   localparam int unsigned RECOVERY_PULSES = 9;
   localparam int unsigned UNIT_HZ         = 20_000_000;

endpackage

// File: rtl/i2c_line_activity.sv
module i2c_line_activity (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic activity
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_in;
         sda_q <= sda_in;
      end
   end

   assign activity = (scl_in != scl_q) || (sda_in != sda_q);
endmodule

// File: rtl/i2c_idle_timer.sv
module i2c_idle_timer #(
   parameter int unsigned TMR_W       = 8,
   parameter int unsigned LONG_TICKS  = 200,
   parameter int unsigned SHORT_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic tick,
   input  logic fast,
   output logic expire
);
   localparam logic [TMR_W-1:0] LONG_LAST  = TMR_W'(LONG_TICKS - 1);
   localparam logic [TMR_W-1:0] SHORT_LAST = TMR_W'(SHORT_TICKS - 1);

   logic [TMR_W-1:0] cnt_q;
   logic [TMR_W-1:0] last;

   assign last   = fast ? SHORT_LAST : LONG_LAST;
   assign expire = run && !clear && tick && (cnt_q >= last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || !run || expire) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_recovery_pulser.sv
module i2c_recovery_pulser
   import i2c_sentinel_pkg::*;
#(
   parameter int unsigned UNIT_TICKS = 1,
   parameter int unsigned UNITS_W    = 8,
   parameter int unsigned PULSES     = RECOVERY_PULSES
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go,
   input  logic               tick,
   input  logic [UNITS_W-1:0] low_units,
   input  logic [UNITS_W-1:0] high_units,
   output logic               pull,
   output logic               done
);
   localparam int unsigned PCNT_W = $clog2(PULSES + 1);
   localparam int unsigned PRE_W  = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;

   pulse_phase_e       phase_q;
   logic [UNITS_W-1:0] ph_cnt_q;
   logic [PCNT_W-1:0]  pulse_q;
   logic               unit;
   logic [UNITS_W-1:0] len;
   logic               phase_end;

   generate
      if (UNIT_TICKS > 1) begin : g_prescale
         logic [PRE_W-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (!go) begin
               pre_q <= '0;
            end else if (tick) begin
               pre_q <= (pre_q == PRE_W'(UNIT_TICKS - 1)) ? '0 : pre_q + 1'b1;
            end
         end
         assign unit = tick && (pre_q == PRE_W'(UNIT_TICKS - 1));
      end else begin : g_direct
         assign unit = tick;
      end
   endgenerate

   always_comb begin
      len = (phase_q == PH_LOW) ? low_units : high_units;
      if (len == '0) len = UNITS_W'(1);
   end

   assign phase_end = go && unit && (ph_cnt_q == len - 1'b1);
   assign pull      = go && (phase_q == PH_LOW);
   assign done      = phase_end && (phase_q == PH_HIGH)
                      && (pulse_q == PCNT_W'(PULSES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_LOW;
         ph_cnt_q <= '0;
         pulse_q  <= '0;
      end else if (!go) begin
         phase_q  <= PH_LOW;
         ph_cnt_q <= '0;
         pulse_q  <= '0;
      end else if (phase_end) begin
         ph_cnt_q <= '0;
         if (phase_q == PH_LOW) begin
            phase_q <= PH_HIGH;
         end else begin
            phase_q <= PH_LOW;
            pulse_q <= pulse_q + 1'b1;
         end
      end else if (unit) begin
         ph_cnt_q <= ph_cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_bus_sentinel.sv
module i2c_bus_sentinel
   import i2c_sentinel_pkg::*;
#(
   parameter int unsigned OSC_HZ   = 20_000_000,
   parameter int unsigned LONG_US  = 1_000_000,
   parameter int unsigned SHORT_US = 50,
   parameter int unsigned UNITS_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               osc_tick,
   input  logic               scl_in,
   input  logic               sda_in,
   input  logic               wd_disable,
   input  logic               wd_fast,
   input  logic [UNITS_W-1:0] low_units,
   input  logic [UNITS_W-1:0] high_units,
   output logic               bus_free,
   output logic               scl_pull,
   output logic               recovering
);
   localparam int unsigned TICKS_PER_US = OSC_HZ / 1_000_000;
   localparam int unsigned LONG_TICKS   = TICKS_PER_US * LONG_US;
   localparam int unsigned SHORT_TICKS  = TICKS_PER_US * SHORT_US;
   localparam int unsigned TMR_W        = $clog2(LONG_TICKS + 1);
   localparam int unsigned RAW_UNIT     = OSC_HZ / UNIT_HZ;
   localparam int unsigned UNIT_TICKS   = (RAW_UNIT < 1) ? 1 : RAW_UNIT;

   generate
      if (OSC_HZ < 1_000_000 || (OSC_HZ % 1_000_000) != 0) begin : g_bad_osc
         $error("OSC_HZ must be a whole number of MHz");
      end
      if (SHORT_US == 0 || SHORT_US >= LONG_US) begin : g_bad_win
         $error("SHORT_US must be nonzero and below LONG_US");
      end
      if (UNITS_W < 2) begin : g_bad_units
         $error("UNITS_W must be at least 2");
      end
   endgenerate

   wd_state_e state_q;
   wd_state_e state_d;
   logic      activity;
   logic      expire;
   logic      tmr_clear;
   logic      tmr_run;
   logic      rec_go;
   logic      rec_pull;
   logic      rec_done;

   i2c_line_activity u_act (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .activity (activity)
   );

   assign tmr_run   = (state_q == WD_WATCH) && !wd_disable;
   assign tmr_clear = activity || wd_disable || (state_q != WD_WATCH);

   i2c_idle_timer #(
      .TMR_W       (TMR_W),
      .LONG_TICKS  (LONG_TICKS),
      .SHORT_TICKS (SHORT_TICKS)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (tmr_clear),
      .run    (tmr_run),
      .tick   (osc_tick),
      .fast   (wd_fast),
      .expire (expire)
   );

   assign rec_go = (state_q == WD_RECOVER);

   i2c_recovery_pulser #(
      .UNIT_TICKS (UNIT_TICKS),
      .UNITS_W    (UNITS_W),
      .PULSES     (RECOVERY_PULSES)
   ) u_pulse (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (rec_go),
      .tick       (osc_tick),
      .low_units  (low_units),
      .high_units (high_units),
      .pull       (rec_pull),
      .done       (rec_done)
   );

   always_comb begin
      state_d = state_q;
      if (wd_disable) begin
         state_d = WD_WATCH;
      end else begin
         unique case (state_q)
            WD_WATCH:   if (expire) state_d = sda_in ? WD_FREE : WD_RECOVER;
            WD_FREE:    if (activity) state_d = WD_WATCH;
            WD_RECOVER: if (sda_in || rec_done) state_d = WD_WATCH;
            default:    state_d = WD_WATCH;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= WD_WATCH;
      else        state_q <= state_d;
   end

   assign bus_free   = (state_q == WD_FREE);
   assign recovering = rec_go;
   assign scl_pull   = rec_pull;
endmodule

// File: rtl/i2c_sentinel_chk.sv
module i2c_sentinel_chk
   import i2c_sentinel_pkg::*;
(
   input logic clk,
   input logic rst_n,
   input logic scl_in,
   input logic sda_in,
   input logic wd_disable,
   input logic bus_free,
   input logic scl_pull,
   input logic recovering
);
   logic       pull_q;
   logic [4:0] rises_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pull_q  <= 1'b0;
         rises_q <= '0;
      end else begin
         pull_q <= scl_pull;
         if (!recovering)            rises_q <= '0;
         else if (scl_pull && !pull_q) rises_q <= rises_q + 1'b1;
      end
   end

   // R12
   pull_only_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scl_pull |-> recovering);

   // R5
   free_excl_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_free && recovering));

   // R11
   disable_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_disable |=> (!bus_free && !recovering && !scl_pull));

   // R8
   sda_high_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (recovering && sda_in) |=> (!scl_pull && !recovering));

   // R10
   free_drop_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_free && ((scl_in != $past(scl_in)) || (sda_in != $past(sda_in))))
      |=> !bus_free);

   // R6
   pulse_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rises_q <= 5'(RECOVERY_PULSES));
endmodule

bind i2c_bus_sentinel i2c_sentinel_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_in     (scl_in),
   .sda_in     (sda_in),
   .wd_disable (wd_disable),
   .bus_free   (bus_free),
   .scl_pull   (scl_pull),
   .recovering (recovering)
);

// File: tb/i2c_bus_sentinel_bench.sv
`timescale 1ns/1ps
module i2c_bus_sentinel_bench;
   localparam int SHORT = 50;
   localparam int LONG  = 2000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_drv = 1'b1;
   logic       sda_in = 1'b1;
   logic       wd_disable = 1'b0;
   logic       wd_fast = 1'b1;
   logic [7:0] low_units = 8'd3;
   logic [7:0] high_units = 8'd2;
   logic       scl_in;
   logic       bus_free;
   logic       scl_pull;
   logic       recovering;

   int errs = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   assign scl_in = scl_drv & ~scl_pull;

   i2c_bus_sentinel #(
      .OSC_HZ   (1_000_000),
      .LONG_US  (LONG),
      .SHORT_US (SHORT)
   ) u_i2c_bus_sentinel (
      .clk        (clk),
      .rst_n      (rst_n),
      .osc_tick   (1'b1),
      .scl_in     (scl_in),
      .sda_in     (sda_in),
      .wd_disable (wd_disable),
      .wd_fast    (wd_fast),
      .low_units  (low_units),
      .high_units (high_units),
      .bus_free   (bus_free),
      .scl_pull   (scl_pull),
      .recovering (recovering)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic scl_blip();
      scl_drv = 1'b0;
      wait_n(1);
      scl_drv = 1'b1;
   endtask

   task automatic t_reset();
      check(!bus_free && !scl_pull && !recovering, "R1 reset outputs",
            {bus_free, scl_pull, recovering}, 0);
   endtask

   task automatic t_free_fast();
      wd_fast = 1'b1; sda_in = 1'b1;
      scl_blip();
      wait_n(SHORT - 3);
      check(!bus_free, "R4 not free before short window", bus_free, 0);
      wait_n(6);
      check(bus_free, "R5 free after short window", bus_free, 1);
      check(!scl_pull && !recovering, "R5 no pulses when SDA high", scl_pull, 0);
      scl_drv = 1'b0;
      wait_n(1);
      check(!bus_free, "R10 free clears on edge", bus_free, 0);
      scl_drv = 1'b1;
      wait_n(1);
   endtask

   task automatic t_restart();
      wd_fast = 1'b1; sda_in = 1'b1;
      scl_blip();
      wait_n(SHORT - 10);
      sda_in = 1'b0;
      wait_n(1);
      sda_in = 1'b1;
      wait_n(SHORT - 3);
      check(!bus_free, "R2 late edge restarts window", bus_free, 0);
      wait_n(6);
      check(bus_free, "R2 free after restarted window", bus_free, 1);
      scl_blip();
   endtask

   task automatic t_long();
      wd_fast = 1'b0; sda_in = 1'b1;
      scl_blip();
      wait_n(LONG - 3);
      check(!bus_free, "R3 not free before long window", bus_free, 0);
      wait_n(6);
      check(bus_free, "R3 free after long window", bus_free, 1);
      scl_blip();
      wd_fast = 1'b1;
   endtask

   // watch one recovery run; abort_at > 0 raises SDA in the high phase of that pulse
   task automatic run_recovery(input int lo, input int hi, input int abort_at);
      int pulses = 0;
      int run = 0;
      bit prev = 1'b0;
      bit aborted = 1'b0;
      int guard = 0;
      while (!recovering && guard < SHORT + 20) begin
         wait_n(1);
         guard++;
      end
      check(recovering, "R6 recovery starts on SDA low timeout", recovering, 1);
      while (recovering && guard < 5000) begin
         if (scl_pull != prev) begin
            if (prev)
               check(run == lo, "R7 pulse low time", run, lo);
            else if (run > 0)
               check(run == hi, "R7 pulse high time", run, hi);
            run = 0;
            if (scl_pull) pulses++;
         end
         if (abort_at > 0 && pulses == abort_at && !scl_pull) begin
            sda_in = 1'b1;
            aborted = 1'b1;
            wait_n(1);
            check(!scl_pull && !recovering, "R8 abort on SDA high",
                  {scl_pull, recovering}, 0);
            break;
         end
         run++;
         prev = scl_pull;
         wait_n(1);
         guard++;
      end
      if (!aborted) begin
         check(run == hi, "R7 last high time", run, hi);
         check(pulses == 9, "R6 pulse count", pulses, 9);
      end
   endtask

   task automatic t_recover();
      wd_fast = 1'b1;
      low_units = 8'd3; high_units = 8'd2;
      sda_in = 1'b0;
      run_recovery(3, 2, 0);
      wait_n(SHORT - 4);
      check(!recovering, "R9 window restarts after recovery", recovering, 0);
      wait_n(7);
      check(recovering, "R9 second recovery after full window", recovering, 1);
      run_recovery(3, 2, 3);
      wait_n(SHORT - 4);
      check(!bus_free, "R9 window restarts after abort", bus_free, 0);
      wait_n(7);
      check(bus_free, "R9 free after abort and window", bus_free, 1);
      scl_blip();
   endtask

   task automatic t_zero_units();
      low_units = 8'd0; high_units = 8'd0;
      sda_in = 1'b0;
      run_recovery(1, 1, 0);
      sda_in = 1'b1;
      wait_n(2);
      low_units = 8'd3; high_units = 8'd2;
   endtask

   task automatic t_disable();
      sda_in = 1'b1;
      scl_blip();
      wait_n(SHORT + 5);
      check(bus_free, "R11 free before disable", bus_free, 1);
      wd_disable = 1'b1;
      wait_n(1);
      check(!bus_free, "R11 disable clears free", bus_free, 0);
      sda_in = 1'b0;
      wait_n(3 * SHORT);
      check(!recovering && !scl_pull && !bus_free, "R11 no recovery while disabled",
            {bus_free, scl_pull, recovering}, 0);
      wd_disable = 1'b0;
      wait_n(SHORT + 5);
      check(recovering, "R11 recovery after re-enable", recovering, 1);
      while (!scl_pull) wait_n(1);
      wd_disable = 1'b1;
      wait_n(1);
      check(!scl_pull && !recovering, "R11 disable stops recovery",
            {scl_pull, recovering}, 0);
      check(!(scl_pull && !recovering), "R12 pull only in recovery", scl_pull, 0);
      sda_in = 1'b1;
      wd_disable = 1'b0;
      wait_n(2);
   endtask

   initial begin
      bit hung = 1'b0;
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      fork
         begin
            t_reset();
            t_free_fast();
            t_restart();
            t_long();
            t_recover();
            t_zero_units();
            t_disable();
         end
         begin
            wait_n(150_000);
            hung = 1'b1;
         end
      join_any
      disable fork;
      if (hung) check(1'b0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule